// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the register file of a colour LCD controller, reached over a simple 32-bit read/write slave bus. It holds the panel timing words, the frame base addresses for the two halves of the panel, the control word, the interrupt mask and the interrupt status. From these it drives the panel geometry, the enable state and the pixel-format fields to the rest of the controller, and it raises one interrupt line.

A built-in frame counter stands in for the display timing. While the controller is enabled it fires once per frame period. Each time it fires, it flags both the next-base-address event and the vertical-compare event. Software masks these events and acknowledges them by writing ones to a clear register.

A parameter selects the variant. The base variant keeps the mask at word 6 and the control word at word 7. The other variants exchange these two words, and the extended variant also returns a different identification signature.

Top module: `lcdc_regs`

## Requirements
- R1: After reset every register reads 0, and `irq`, `lcd_on` and all control fields are low.
- R2: Word offsets 0 to 3 are the timing words and offsets 4 and 5 are the upper and lower base addresses. All of them read back the written value. Word offset 11 returns the upper base and word offset 12 returns the lower base.
- R3: With VARIANT=0, word 6 is the mask and word 7 is control. With any other VARIANT the two are exchanged, for both reads and writes.
- R4: `lcd_on` is high only when control bit 0 (enable) and bit 11 (power) are both 1. `pix_depth` is control bits [3:1], `bgr` is bit 8, `be_byte` is bit 9 and `be_pixel` is bit 10.
- R5: `panel_width` is (timing0[7:2]+1)*16 and `panel_height` is timing1[9:0]+1.
- R6: While `lcd_on` is high, the frame counter sets raw status bit 2 (next base) and bit 3 (vertical compare) together. This happens every FRAME_CYCLES cycles, and the first set lands FRAME_CYCLES cycles after the write that enabled the controller.
- R7: While `lcd_on` is low, no status bit is set. Re-enabling restarts the frame period from zero.
- R8: `irq` is high exactly when (raw status AND mask) is nonzero. Word 8 reads raw status and word 9 reads raw AND mask.
- R9: A write to word 10 clears every raw status bit whose written bit is 1, and `irq` follows in the next cycle.
- R10: Byte offsets 0xFE0 to 0xFFC return one identification byte per word: 10, 11, 04, 00, 0D, F0, 05, B1 (hex). With VARIANT=2 the first byte is 11 and the third is 24.
- R11: Undefined offsets read 0 and ignore writes. Writes to words 8 and 9 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits [11:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| irq | output | 1 | Combined interrupt |
| lcd_on | output | 1 | Controller enabled and powered |
| pix_depth | output | 3 | Pixel depth code |
| bgr | output | 1 | Blue/red swap |
| be_byte | output | 1 | Big-endian byte order |
| be_pixel | output | 1 | Big-endian pixel order within a byte |
| panel_width | output | 11 | Panel width in pixels |
| panel_height | output | 11 | Panel height in lines |

## Verification
The bench places the first frame event exactly: it reads status one cycle before the event is due and again one cycle after. An off-by-one counter, or one that keeps running while the controller is off, fails one of these two reads. A second pass disables the controller half-way through a frame and re-enables it, so a counter that is not restarted fires early. Two further checks confirm that enable alone or power alone keeps the counter still, and that the width and height arithmetic uses the right bit fields at both ends of their range. A second instance built with the swapped variant receives the same writes to words 6 and 7, so a swap applied to reads only, or to writes only, gives mismatched values.

// File: rtl/lcdc_regs.sv
module lcdc_regs #(
  parameter int VARIANT      = 0,
  parameter int FRAME_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        lcd_on,
  output logic [2:0]  pix_depth,
  output logic        bgr,
  output logic        be_byte,
  output logic        be_pixel,
  output logic [10:0] panel_width,
  output logic [10:0] panel_height
);
  localparam int CW      = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;
  localparam int MASK_WD = (VARIANT == 0) ? 6 : 7;
  localparam int CTRL_WD = (VARIANT == 0) ? 7 : 6;

  logic [31:0] tim_q [4];
  logic [31:0] upb_q, lpb_q, mask_q, ctrl_q;
  logic [1:0]  st_q;
  logic [CW-1:0] cnt_q;
  logic        tick;
  logic [9:0]  word;
  logic        wr;
  logic [31:0] raw;

  assign word = bus_addr[11:2];
  assign wr   = bus_en && bus_wr;
  assign raw  = {28'd0, st_q, 2'b00};

  assign lcd_on    = ctrl_q[0] && ctrl_q[11];
  assign pix_depth = ctrl_q[3:1];
  assign bgr       = ctrl_q[8];
  assign be_byte   = ctrl_q[9];
  assign be_pixel  = ctrl_q[10];
  assign panel_width  = ({5'd0, tim_q[0][7:2]} + 11'd1) << 4;
  assign panel_height = {1'b0, tim_q[1][9:0]} + 11'd1;
  assign irq = |(raw & mask_q);
  assign tick = lcd_on && (cnt_q == CW'(FRAME_CYCLES - 1));

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0: id_byte = (VARIANT == 2) ? 8'h11 : 8'h10;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = (VARIANT == 2) ? 8'h24 : 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) tim_q[i] <= '0;
      upb_q <= '0; lpb_q <= '0; mask_q <= '0; ctrl_q <= '0;
    end else if (wr) begin
      if (word < 10'd4) tim_q[word[1:0]] <= bus_wdata;
      if (word == 10'd4) upb_q <= bus_wdata;
      if (word == 10'd5) lpb_q <= bus_wdata;
      if (word == 10'(MASK_WD)) mask_q <= bus_wdata;
      if (word == 10'(CTRL_WD)) ctrl_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !lcd_on || tick) cnt_q <= '0;
    else cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else if (tick) st_q <= 2'b11;
    else if (wr && word == 10'd10) st_q <= st_q & ~bus_wdata[3:2];
  end

  always_comb begin
    bus_rdata = '0;
    if (word >= 10'h3F8) bus_rdata = {24'd0, id_byte(word[2:0])};
    else if (word < 10'd4) bus_rdata = tim_q[word[1:0]];
    else if (word == 10'd4 || word == 10'd11) bus_rdata = upb_q;
    else if (word == 10'd5 || word == 10'd12) bus_rdata = lpb_q;
    else if (word == 10'(MASK_WD)) bus_rdata = mask_q;
    else if (word == 10'(CTRL_WD)) bus_rdata = ctrl_q;
    else if (word == 10'd8) bus_rdata = raw;
    else if (word == 10'd9) bus_rdata = raw & mask_q;
  end
endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_en,
  input logic        bus_wr,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic        irq,
  input logic        lcd_on,
  input logic [10:0] panel_width,
  input logic [10:0] panel_height,
  input logic [1:0]  st_q,
  input logic [31:0] ctrl_q,
  input logic        tick
);
  // R7
  gated_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[1]) |-> $past(lcd_on));
  // R6
  tick_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> st_q == 2'b11);
  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_addr[11:2] == 10'd10 && bus_wdata[2] && !tick) |=> !st_q[0]);
  // R8
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 2'b00) |-> !irq);
  // R5
  width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    panel_width[3:0] == 4'd0 && panel_width != 11'd0);
  // R5
  height_chk: assert property (@(posedge clk) disable iff (!rst_n)
    panel_height != 11'd0);
  // R11
  undef_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_addr[11:2] == 10'd13) |=> $stable(ctrl_q));
endmodule

bind lcdc_regs lcdc_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq), .lcd_on(lcd_on),
  .panel_width(panel_width), .panel_height(panel_height),
  .st_q(st_q), .ctrl_q(ctrl_q), .tick(tick)
);

// File: tb/lcdc_regs_tb_top.sv
module lcdc_regs_tb_top;
  localparam int PER = 10;
  localparam int F   = 40;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_wr = 0, x_sel = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd0, rd1;
  logic irq0, on0, bgr0, bb0, bp0, irq1, on1, bgr1, bb1, bp1;
  logic [2:0] dp0, dp1;
  logic [10:0] w0, h0, w1, h1;

  always #(PER/2) clk = ~clk;

  lcdc_regs #(.VARIANT(0), .FRAME_CYCLES(F)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .irq(irq0), .lcd_on(on0), .pix_depth(dp0),
    .bgr(bgr0), .be_byte(bb0), .be_pixel(bp0), .panel_width(w0), .panel_height(h0));

  lcdc_regs #(.VARIANT(2), .FRAME_CYCLES(F)) dut_x (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en && x_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .irq(irq1), .lcd_on(on1), .pix_depth(dp1),
    .bgr(bgr1), .be_byte(bb1), .be_pixel(bp1), .panel_width(w1), .panel_height(h1));

  typedef struct {
    logic [31:0] e0;
    logic [31:0] e1;
    logic        use1;
    string       tag;
  } item_t;
  item_t q[$];

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_en && !bus_wr && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(rd0, it.e0, it.tag);
      if (it.use1) chk(rd1, it.e1, {it.tag, " (variant 2)"});
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e0, input logic [31:0] e1,
                    input logic use1, input string tag);
    item_t it;
    it.e0 = e0; it.e1 = e1; it.use1 = use1; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
    bus_en = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_en = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(PER * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  task automatic tick_window(input string tag);
    wr(12'h01C, 32'h0000_0801);
    repeat (F - 2) @(posedge clk);
    rd(12'h020, 0, 0, 0, {tag, " R6 before frame end"});
    rd(12'h020, 32'hC, 0, 0, {tag, " R6 at frame end"});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    chk(irq0, 0, "R1 irq"); chk(on0, 0, "R1 lcd_on"); chk(dp0, 0, "R1 depth");
    rd(12'h01C, 0, 0, 0, "R1 control");
    rd(12'h010, 0, 0, 0, "R1 upper base");
    // R2
    wr(12'h008, 32'hDEAD_BEEF); rd(12'h008, 32'hDEAD_BEEF, 0, 0, "R2 timing2");
    wr(12'h00C, 32'h1234_5678); rd(12'h00C, 32'h1234_5678, 0, 0, "R2 timing3");
    wr(12'h010, 32'h8000_1000); wr(12'h014, 32'h8004_0000);
    rd(12'h010, 32'h8000_1000, 0, 0, "R2 upper base");
    rd(12'h02C, 32'h8000_1000, 0, 0, "R2 upper current");
    rd(12'h030, 32'h8004_0000, 0, 0, "R2 lower current");
    // R5
    wr(12'h000, 32'h0000_00FC); wr(12'h004, 32'h0000_03FF); @(negedge clk);
    chk(w0, 1024, "R5 width max"); chk(h0, 1024, "R5 height max");
    wr(12'h000, 32'hFFFF_FF07); wr(12'h004, 32'hFFFF_FC00); @(negedge clk);
    chk(w0, 32, "R5 width fields"); chk(h0, 1, "R5 height fields");
    // R4
    wr(12'h01C, 32'h0000_0001); @(negedge clk); chk(on0, 0, "R4 enable only");
    wr(12'h01C, 32'h0000_0800); @(negedge clk); chk(on0, 0, "R4 power only");
    repeat (2 * F) @(posedge clk);
    rd(12'h020, 0, 0, 0, "R7 no tick while off");
    wr(12'h01C, 32'h0000_070A); @(negedge clk);
    chk({bp0, bb0, bgr0, dp0}, 6'b111101, "R4 format fields"); chk(on0, 0, "R4 off");
    // R6
    tick_window("first");
    @(negedge clk); chk(on0, 1, "R4 enabled");
    wr(12'h01C, 32'h0000_0001);
    // R8
    @(negedge clk); chk(irq0, 0, "R8 masked off");
    wr(12'h018, 32'h0000_0008); @(negedge clk); chk(irq0, 1, "R8 irq on vcomp");
    rd(12'h024, 32'h8, 0, 0, "R8 masked status");
    // R11
    wr(12'h020, 32'h0); wr(12'h024, 32'h0);
    rd(12'h020, 32'hC, 0, 0, "R11 raw status write ignored");
    // R9
    wr(12'h028, 32'h0000_0004); @(negedge clk); chk(irq0, 1, "R9 irq kept");
    rd(12'h020, 32'h8, 0, 0, "R9 partial clear");
    wr(12'h028, 32'h0000_0008); @(negedge clk); chk(irq0, 0, "R9 irq dropped");
    rd(12'h024, 0, 0, 0, "R9 masked zero");
    // R7 restart
    wr(12'h01C, 32'h0000_0801);
    repeat (F / 2) @(posedge clk);
    wr(12'h01C, 32'h0000_0001);
    rd(12'h020, 0, 0, 0, "R7 no tick after early disable");
    tick_window("restart R7");
    wr(12'h01C, 32'h0);
    // R11
    wr(12'h034, 32'hFFFF_FFFF);
    rd(12'h034, 0, 0, 0, "R11 undefined read");
    rd(12'h01C, 0, 0, 0, "R11 control untouched");
    rd(12'h200, 0, 0, 0, "R11 unmapped window");
    // R10
    x_sel = 1;
    rd(12'hFE0, 8'h10, 8'h11, 1, "R10 id0");
    rd(12'hFE4, 8'h11, 8'h11, 1, "R10 id1");
    rd(12'hFE8, 8'h04, 8'h24, 1, "R10 id2");
    rd(12'hFEC, 8'h00, 8'h00, 1, "R10 id3");
    rd(12'hFF0, 8'h0D, 8'h0D, 1, "R10 id4");
    rd(12'hFF4, 8'hF0, 8'hF0, 1, "R10 id5");
    rd(12'hFF8, 8'h05, 8'h05, 1, "R10 id6");
    rd(12'hFFC, 8'hB1, 8'hB1, 1, "R10 id7");
    // R3
    wr(12'h018, 32'h0000_0801); wr(12'h01C, 32'h0000_0008);
    @(negedge clk);
    chk(on1, 1, "R3 variant word6 is control"); chk(dp0, 4, "R3 base word7 is control");
    chk(on0, 0, "R3 base word6 is mask");
    rd(12'h018, 32'h801, 32'h801, 1, "R3 word6 readback");
    rd(12'h01C, 32'h8, 32'h8, 1, "R3 word7 readback");
    x_sel = 0;
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule